// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Line Error Signalling

This block is an asynchronous, half-duplex character transceiver for a smart-card contact interface. It shifts out characters from a one-entry transmit buffer and assembles incoming characters into a one-entry receive buffer. Every character has a start bit, eight data bits, one even-parity bit and one stop bit. A selectable line convention either sends true levels least-significant bit first, or sends inverted levels most-significant bit first.

A programmable divider sets the bit rate from either an internal prescaled clock or an external clock pin. The receiver reports a parity failure to the far end by holding its own transmit line low for one bit time. The transmitter learns of a failure reported by the far end by sampling the receive line in the middle of its stop bit, at the moment it raises its transmit interrupt. Error flags, a combined error flag and two single-cycle interrupt pulses let the surrounding logic react.

Top module: `card_uart`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, and `rx_full`, `tx_nack`, `tx_irq`, `rx_irq`, `err_overrun`, `err_frame`, `err_parity` and `err_sum` are all 0.
- R2: One bit lasts 16*(`div_n`+1) source ticks. With `clk_sel`=0 a source tick is PRESCALE cycles of `clk`. With `clk_sel`=1 a source tick is each rising edge of `ext_clk`.
- R3: A `tx_wr` pulse stores `tx_wdata` and clears `tx_empty` on the next cycle. A character is sent only while `tx_en`=1 and `tx_empty`=0, and `tx_empty` returns to 1 when the transmitter takes the character.
- R4: With `inverse`=0, a transmitted frame is: a low start bit, data bits 0 to 7 at true level, a parity bit making the count of ones in the data and parity even, and a high stop bit.
- R5: With `inverse`=1, data and parity are inverted on the line and the data goes bit 7 first. Start (low) and stop (high) are unchanged. The receiver decodes the same way.
- R6: `tx_irq` pulses for exactly one cycle per character, at the middle of the stop bit. `tx_nack` then becomes 1 if `rxd` was low at that point and 0 otherwise. `tx_nack` clears when the next character is taken.
- R7: Reception starts only with `rx_en`=1 and a low start bit that is still low at its middle. When the stop bit is sampled, the character is moved into `rx_rdata`, `rx_full` goes to 1 and `rx_irq` pulses for one cycle.
- R8: A received parity mismatch sets `err_parity`. `txd` is then held low for one bit time, starting half a bit after the parity sample point. When parity is correct, `txd` stays high.
- R9: A stop bit sampled low sets `err_frame`. The character is still moved into the buffer.
- R10: If `rx_full` is still 1 when the parity bit of the next character is sampled, `err_overrun` is set. That character raises no `rx_irq` and `rx_rdata` keeps the unread character.
- R11: `err_sum` is 1 whenever any of the three error flags is 1. A `rx_rd` pulse clears `rx_full` and the error flags. `rx_en`=0 clears the error flags and blocks `rx_irq`.
- R12: If `rx_rd` is high on the same clock edge that moves a new character into the buffer, the new character wins: `rx_full` stays 1 and `rx_rdata` holds the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_sel | input | 1 | Bit-clock source: 0 internal prescaler, 1 external pin |
| ext_clk | input | 1 | External clock source, sampled on `clk` |
| div_n | input | DIVW | Divider setting n |
| inverse | input | 1 | 1 selects the inverted, MSB-first convention |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | DW | Character to transmit |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, also carries the error signal |
| tx_empty | output | 1 | Transmit buffer holds no unsent character |
| tx_nack | output | 1 | Far end signalled an error on the last character sent |
| tx_irq | output | 1 | One-cycle pulse when a character has been sent |
| rx_rdata | output | DW | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_irq | output | 1 | One-cycle pulse when a character enters the buffer |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing flag |
| err_parity | output | 1 | Parity flag |
| err_sum | output | 1 | Any error flag set |

## Verification
Two things can happen on the same clock edge: software reads the receive buffer, and the receiver moves a freshly completed character into that buffer. To force this, the bench holds `rx_rd` high for the whole incoming character. It drops the strobe at the falling edge where it first sees `rx_irq`, so the read and the load share exactly one rising edge. The result is judged at the ports: `rx_full` must still be 1 and `rx_rdata` must show the new character. Had the read won, the buffer would appear empty.

// File: rtl/card_uart_pkg.sv
// Shared constants and state types for the smart-card UART.
// Assumes an oversampling rate that is a power of two, so the sub-bit
// counter wraps by itself at the end of every bit.
package card_uart_pkg;
    localparam int OSR = 16;
    localparam int OSW = $clog2(OSR);
    localparam logic [OSW-1:0] MID  = OSW'(OSR / 2 - 1);
    localparam logic [OSW-1:0] LAST = OSW'(OSR - 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_GUARD
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;
endpackage

// File: rtl/card_uart_baud.sv
// Oversampling tick generator. Picks an internal prescaled tick or the
// rising edge of a synchronised external clock, then divides by (div_n+1).
// Assumes ext_clk is slower than half the clk rate.
module card_uart_baud #(
    parameter int DIVW     = 8,
    parameter int PRESCALE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_sel,
    input  logic            ext_clk,
    input  logic [DIVW-1:0] div_n,
    output logic            os_tick
);
    logic            int_tick;
    logic [2:0]      ext_sync;
    logic            src_tick;
    logic [DIVW-1:0] dcnt;

    generate
        if (PRESCALE <= 1) begin : g_nopre
            assign int_tick = 1'b1;
        end else begin : g_pre
            localparam int PW = $clog2(PRESCALE);
            logic [PW-1:0] pcnt;
            // Count clk cycles to form the internal source tick.
            always_ff @(posedge clk) begin
                if (!rst_n)                          pcnt <= '0;
                else if (pcnt == PW'(PRESCALE - 1))  pcnt <= '0;
                else                                 pcnt <= pcnt + 1'b1;
            end
            assign int_tick = (pcnt == PW'(PRESCALE - 1));
        end
    endgenerate

    // Synchronise the external clock and keep one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk};
    end

    assign src_tick = clk_sel ? (ext_sync[1] & ~ext_sync[2]) : int_tick;
    assign os_tick  = src_tick && (dcnt >= div_n);

    // Divide the source tick by div_n+1.
    always_ff @(posedge clk) begin
        if (!rst_n)        dcnt <= '0;
        else if (src_tick) dcnt <= (dcnt >= div_n) ? '0 : dcnt + 1'b1;
    end
endmodule

// File: rtl/card_uart_tx.sv
// Transmit shifter. Sends start, data, parity and stop, then one guard bit.
// In the middle of the stop bit it pulses irq and samples the receive line
// for an error signal from the far end. Assumes inverse is static per frame.
module card_uart_tx
    import card_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          inverse,
    input  logic          start,
    input  logic [DW-1:0] din,
    input  logic          rxd_s,
    output logic          line,
    output logic          load,
    output logic          irq,
    output logic          nack_bit
);
    localparam int BW = $clog2(DW);

    tx_state_e      st;
    logic [OSW-1:0] cnt;
    logic [BW-1:0]  bidx;
    logic [DW-1:0]  sh;
    logic           par;
    logic           bit_end;
    logic           cur;

    assign load    = start && (st == TX_IDLE);
    assign bit_end = os_tick && (cnt == LAST);
    assign cur     = inverse ? sh[DW-1] : sh[0];

    // Line level for the current frame position.
    always_comb begin
        case (st)
            TX_START: line = 1'b0;
            TX_DATA:  line = cur ^ inverse;
            TX_PAR:   line = par ^ inverse;
            default:  line = 1'b1;
        endcase
    end

    // Frame sequencer, shifter and stop-bit error sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            sh       <= '0;
            par      <= 1'b0;
            irq      <= 1'b0;
            nack_bit <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                st   <= TX_START;
                cnt  <= '0;
                bidx <= '0;
                sh   <= din;
                par  <= ^din;
            end else if (st != TX_IDLE && os_tick) begin
                cnt <= cnt + 1'b1;
            end
            if (bit_end) begin
                case (st)
                    TX_START: st <= TX_DATA;
                    TX_DATA: begin
                        sh   <= inverse ? {sh[DW-2:0], 1'b0} : {1'b0, sh[DW-1:1]};
                        bidx <= bidx + 1'b1;
                        if (bidx == BW'(DW - 1)) st <= TX_PAR;
                    end
                    TX_PAR:   st <= TX_STOP;
                    TX_STOP:  st <= TX_GUARD;
                    TX_GUARD: st <= TX_IDLE;
                    default:  st <= TX_IDLE;
                endcase
            end
            if (st == TX_STOP && os_tick && cnt == MID) begin
                irq      <= 1'b1;
                nack_bit <= ~rxd_s;
            end
        end
    end
endmodule

// File: rtl/card_uart_rx.sv
// Receive shifter. Detects a start bit, samples each bit at its middle,
// checks even parity and the stop bit. While a parity error is pending it
// asks for the line to be held low through the stop-bit slot.
// Assumes rxd_s is already synchronised to clk.
module card_uart_rx
    import card_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          inverse,
    input  logic          en,
    input  logic          rxd_s,
    input  logic          buf_full,
    output logic          done,
    output logic [DW-1:0] dout,
    output logic          perr,
    output logic          ferr,
    output logic          ovr_hit,
    output logic          nack
);
    localparam int BW = $clog2(DW);

    rx_state_e      st;
    logic [OSW-1:0] cnt;
    logic [BW-1:0]  bidx;
    logic           ovr_q;
    logic           bitv;
    logic           mid;
    logic           bit_end;

    assign bitv    = rxd_s ^ inverse;
    assign mid     = os_tick && (cnt == MID);
    assign bit_end = os_tick && (cnt == LAST);
    assign nack    = (st == RX_STOP) && perr;

    // Frame sequencer, bit sampler and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            dout    <= '0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            ovr_q   <= 1'b0;
            done    <= 1'b0;
            ovr_hit <= 1'b0;
        end else begin
            done    <= 1'b0;
            ovr_hit <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else if (st == RX_IDLE) begin
                if (os_tick && !rxd_s) begin
                    st    <= RX_START;
                    cnt   <= '0;
                    bidx  <= '0;
                    perr  <= 1'b0;
                    ovr_q <= 1'b0;
                end
            end else begin
                if (os_tick) cnt <= cnt + 1'b1;
                if (mid) begin
                    case (st)
                        RX_START: if (rxd_s) st <= RX_IDLE;
                        RX_DATA:  dout <= inverse ? {dout[DW-2:0], bitv} : {bitv, dout[DW-1:1]};
                        RX_PAR: begin
                            perr    <= (^dout) ^ bitv;
                            ovr_q   <= buf_full;
                            ovr_hit <= buf_full;
                        end
                        RX_STOP: begin
                            ferr <= ~rxd_s;
                            done <= ~ovr_q;
                        end
                        default: ;
                    endcase
                end
                if (bit_end) begin
                    case (st)
                        RX_START: st <= RX_DATA;
                        RX_DATA: begin
                            bidx <= bidx + 1'b1;
                            if (bidx == BW'(DW - 1)) st <= RX_PAR;
                        end
                        RX_PAR:  st <= RX_STOP;
                        default: st <= RX_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/card_uart.sv
// Smart-card half-duplex UART top. Holds the one-entry transmit and receive
// buffers, the error flags and the interrupt pulses. Merges the receiver's
// error signal onto the transmit line. Assumes rxd and ext_clk are asynchronous.
module card_uart #(
    parameter int DW       = 8,
    parameter int DIVW     = 8,
    parameter int PRESCALE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_sel,
    input  logic            ext_clk,
    input  logic [DIVW-1:0] div_n,
    input  logic            inverse,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic            tx_wr,
    input  logic [DW-1:0]   tx_wdata,
    input  logic            rx_rd,
    input  logic            rxd,
    output logic            txd,
    output logic            tx_empty,
    output logic            tx_nack,
    output logic            tx_irq,
    output logic [DW-1:0]   rx_rdata,
    output logic            rx_full,
    output logic            rx_irq,
    output logic            err_overrun,
    output logic            err_frame,
    output logic            err_parity,
    output logic            err_sum
);
    logic [1:0]    rxd_sync;
    logic          rxd_s;
    logic          os_tick;
    logic [DW-1:0] tbuf;
    logic          tx_line, tx_load, tx_nack_bit;
    logic          rx_done, rx_perr, rx_ferr, rx_ovr_hit, rx_nack;
    logic [DW-1:0] rx_word;

    // Two-stage synchroniser for the receive line (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end
    assign rxd_s = rxd_sync[1];

    card_uart_baud #(.DIVW(DIVW), .PRESCALE(PRESCALE)) u_baud (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
        .div_n(div_n), .os_tick(os_tick)
    );

    card_uart_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .inverse(inverse),
        .start(tx_en && !tx_empty), .din(tbuf), .rxd_s(rxd_s),
        .line(tx_line), .load(tx_load), .irq(tx_irq), .nack_bit(tx_nack_bit)
    );

    card_uart_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .inverse(inverse),
        .en(rx_en), .rxd_s(rxd_s), .buf_full(rx_full), .done(rx_done),
        .dout(rx_word), .perr(rx_perr), .ferr(rx_ferr), .ovr_hit(rx_ovr_hit),
        .nack(rx_nack)
    );

    assign txd     = tx_line & ~rx_nack;
    assign err_sum = err_overrun | err_frame | err_parity;

    // Transmit buffer: a write wins over the shifter taking the old entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbuf     <= '0;
            tx_empty <= 1'b1;
        end else if (tx_wr) begin
            tbuf     <= tx_wdata;
            tx_empty <= 1'b0;
        end else if (tx_load) begin
            tx_empty <= 1'b1;
        end
    end

    // Far-end error result, captured with the transmit interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_nack <= 1'b0;
        else if (tx_irq)  tx_nack <= tx_nack_bit;
        else if (tx_load) tx_nack <= 1'b0;
    end

    // Receive buffer: a completed character wins over a same-edge read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rdata <= '0;
            rx_full  <= 1'b0;
            rx_irq   <= 1'b0;
        end else begin
            rx_irq <= rx_done && rx_en;
            if (rx_done && rx_en) begin
                rx_rdata <= rx_word;
                rx_full  <= 1'b1;
            end else if (rx_rd) begin
                rx_full  <= 1'b0;
            end
        end
    end

    // Error flags: disable clears all; a new event wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
        end else begin
            if (rx_ovr_hit) err_overrun <= 1'b1;
            else if (rx_rd) err_overrun <= 1'b0;
            if (rx_done) begin
                err_frame  <= rx_ferr;
                err_parity <= rx_perr;
            end else if (rx_rd) begin
                err_frame  <= 1'b0;
                err_parity <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/card_uart_chk.sv
// Port-level protocol checks for card_uart, attached by bind.
module card_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic tx_empty,
    input logic tx_irq,
    input logic rx_en,
    input logic rx_rd,
    input logic rx_irq,
    input logic rx_full,
    input logic err_overrun,
    input logic err_frame,
    input logic err_parity
);
    AST_TX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R6
    AST_RX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R7
    AST_RX_IRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full); // R7
    AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty); // R3
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> (rx_irq || (!rx_full && !err_frame && !err_parity))); // R11
    AST_RXDIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_irq && !err_overrun && !err_frame && !err_parity)); // R11
endmodule

bind card_uart card_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
    .tx_irq(tx_irq), .rx_en(rx_en), .rx_rd(rx_rd), .rx_irq(rx_irq),
    .rx_full(rx_full), .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity)
);

// File: tb/card_uart_tb.sv
// Directed bench for card_uart: one task per scenario, each self-checking.
module card_uart_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BC0 = 16;   // bit length in clk cycles with div_n=0, internal

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic [7:0] div_n = 8'd0;
    logic       inverse = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = 8'd0;
    logic       rx_rd = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, tx_empty, tx_nack, tx_irq, rx_full, rx_irq;
    logic       err_overrun, err_frame, err_parity, err_sum;
    logic [7:0] rx_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int n_txirq = 0;
    int n_rxirq = 0;
    logic mid_par_txd, mid_stop_txd;

    card_uart u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
        .div_n(div_n), .inverse(inverse), .tx_en(tx_en), .rx_en(rx_en),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rxd(rxd),
        .txd(txd), .tx_empty(tx_empty), .tx_nack(tx_nack), .tx_irq(tx_irq),
        .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_irq(rx_irq),
        .err_overrun(err_overrun), .err_frame(err_frame),
        .err_parity(err_parity), .err_sum(err_sum)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always #(2 * CLK_PERIOD) ext_clk = ~ext_clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_irq) n_txirq++;
            if (rx_irq) n_rxirq++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] d);
        tx_wdata = d; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        rx_rd = 1'b1; cyc(1); rx_rd = 1'b0; cyc(1);
    endtask

    task automatic wait_txd(input logic lvl);
        int w = 0;
        while (txd !== lvl && w < 5000) begin cyc(1); w++; end
    endtask

    // Drive one character onto rxd; record txd at mid parity and mid stop.
    task automatic drive_char(input logic [7:0] d, input logic inv,
                              input logic badpar, input logic badstop, input int bc);
        logic [10:0] lv;
        lv[0] = 1'b0;
        for (int i = 0; i < 8; i++) lv[1+i] = (inv ? d[7-i] : d[i]) ^ inv;
        lv[9]  = (^d) ^ badpar ^ inv;
        lv[10] = ~badstop;
        for (int k = 0; k < 11; k++) begin
            rxd = lv[k];
            cyc(bc / 2);
            if (k == 9)  mid_par_txd  = txd;
            if (k == 10) mid_stop_txd = txd;
            cyc(bc - bc / 2);
        end
        rxd = 1'b1;
    endtask

    // Sample a character from txd and decode it.
    task automatic capture(input logic inv, input int bc, output logic [7:0] d,
                           output logic pok, output logic sok);
        logic [10:0] lv;
        wait_txd(1'b0);
        cyc(bc / 2);
        lv[0] = txd;
        for (int k = 1; k < 11; k++) begin cyc(bc); lv[k] = txd; end
        for (int i = 0; i < 8; i++) begin
            if (inv) d[7-i] = lv[1+i] ^ inv;
            else     d[i]   = lv[1+i];
        end
        pok = ((lv[9] ^ inv) == (^d)) && (lv[0] == 1'b0);
        sok = lv[10];
    endtask

    task automatic t_reset();
        chk("R1", "txd", txd, 1);
        chk("R1", "tx_empty", tx_empty, 1);
        chk("R1", "rx_full", rx_full, 0);
        chk("R1", "tx_nack", tx_nack, 0);
        chk("R1", "irqs", {tx_irq, rx_irq}, 0);
        chk("R1", "flags", {err_overrun, err_frame, err_parity, err_sum}, 0);
    endtask

    task automatic t_tx_direct();
        logic [7:0] d; logic pok, sok; int lows = 0; int base;
        tx_en = 1'b0;
        write_tx(8'hA5);
        chk("R3", "tx_empty after write", tx_empty, 0);
        for (int i = 0; i < 60; i++) begin cyc(1); if (!txd) lows++; end
        chk("R3", "txd quiet while disabled", lows, 0);
        chk("R3", "buffer kept while disabled", tx_empty, 0);
        base = n_txirq;
        tx_en = 1'b1;
        capture(1'b0, BC0, d, pok, sok);
        chk("R3", "tx_empty after take", tx_empty, 1);
        chk("R4", "direct data", d, 8'hA5);
        chk("R4", "direct parity/start", pok, 1);
        chk("R4", "direct stop", sok, 1);
        cyc(2 * BC0);
        chk("R6", "one tx_irq", n_txirq - base, 1);
        chk("R6", "no nack", tx_nack, 0);
    endtask

    task automatic t_tx_nack();
        int base = n_txirq;
        rx_en = 1'b0;
        write_tx(8'h3C);
        wait_txd(1'b0);
        cyc(150); rxd = 1'b0;
        cyc(30);  rxd = 1'b1;
        cyc(40);
        chk("R6", "nack seen", tx_nack, 1);
        chk("R6", "one tx_irq with nack", n_txirq - base, 1);
    endtask

    task automatic t_tx_inverse();
        logic [7:0] d; logic pok, sok;
        inverse = 1'b1;
        write_tx(8'h1E);
        cyc(3);
        chk("R6", "nack cleared on take", tx_nack, 0);
        capture(1'b1, BC0, d, pok, sok);
        chk("R5", "inverse data", d, 8'h1E);
        chk("R5", "inverse parity/start", pok, 1);
        chk("R5", "inverse stop", sok, 1);
        cyc(2 * BC0);
        inverse = 1'b0;
    endtask

    task automatic measure(input int exp, input string what);
        int w = 0;
        write_tx(8'h01);
        wait_txd(1'b0);
        wait_txd(1'b1);
        while (txd === 1'b1 && w < 5000) begin cyc(1); w++; end
        chk("R2", what, w, exp);
        cyc(11 * exp);
    endtask

    task automatic t_rate();
        div_n = 8'd2;
        measure(48, "internal bit length n=2");
        clk_sel = 1'b1; div_n = 8'd1;
        measure(128, "external bit length n=1");
        clk_sel = 1'b0; div_n = 8'd0;
        cyc(4);
    endtask

    task automatic t_rx_direct();
        int base = n_rxirq;
        rx_en = 1'b0;
        drive_char(8'h99, 1'b0, 1'b0, 1'b0, BC0);
        cyc(20);
        chk("R7", "no irq while disabled", n_rxirq - base, 0);
        chk("R7", "no fill while disabled", rx_full, 0);
        rx_en = 1'b1;
        cyc(2);
        drive_char(8'h5A, 1'b0, 1'b0, 1'b0, BC0);
        cyc(20);
        chk("R7", "one rx_irq", n_rxirq - base, 1);
        chk("R7", "rx_full", rx_full, 1);
        chk("R7", "rx data", rx_rdata, 8'h5A);
        chk("R7", "no errors", err_sum, 0);
        chk("R8", "no error signal", mid_stop_txd, 1);
        read_rx();
        chk("R11", "read empties", rx_full, 0);
    endtask

    task automatic t_rx_inverse();
        inverse = 1'b1;
        drive_char(8'h1E, 1'b1, 1'b0, 1'b0, BC0);
        cyc(20);
        chk("R5", "inverse rx data", rx_rdata, 8'h1E);
        chk("R5", "inverse rx clean", err_sum, 0);
        read_rx();
        inverse = 1'b0;
    endtask

    task automatic t_rx_parity();
        int base = n_rxirq;
        drive_char(8'h6B, 1'b0, 1'b1, 1'b0, BC0);
        cyc(24);
        chk("R8", "txd high in parity bit", mid_par_txd, 1);
        chk("R8", "txd low in stop slot", mid_stop_txd, 0);
        chk("R8", "txd released", txd, 1);
        chk("R8", "err_parity", err_parity, 1);
        chk("R8", "still delivered", n_rxirq - base, 1);
        chk("R11", "err_sum on parity", err_sum, 1);
        read_rx();
        chk("R11", "read clears parity", {err_parity, err_sum}, 0);
    endtask

    task automatic t_rx_frame();
        drive_char(8'h42, 1'b0, 1'b0, 1'b1, BC0);
        cyc(20);
        chk("R9", "err_frame", err_frame, 1);
        chk("R9", "data kept", rx_rdata, 8'h42);
        chk("R11", "err_sum on frame", err_sum, 1);
        rx_en = 1'b0;
        cyc(1);
        chk("R11", "disable clears", {err_frame, err_sum}, 0);
        rx_en = 1'b1;
        read_rx();
    endtask

    task automatic t_rx_overrun();
        int base = n_rxirq;
        drive_char(8'h11, 1'b0, 1'b0, 1'b0, BC0);
        cyc(4);
        drive_char(8'h22, 1'b0, 1'b0, 1'b0, BC0);
        cyc(20);
        chk("R10", "irq only for first", n_rxirq - base, 1);
        chk("R10", "err_overrun", err_overrun, 1);
        chk("R10", "old data kept", rx_rdata, 8'h11);
        chk("R11", "err_sum on overrun", err_sum, 1);
        read_rx();
        chk("R11", "read clears overrun", {err_overrun, rx_full}, 0);
    endtask

    task automatic t_collision();
        rx_rd = 1'b1;
        fork
            drive_char(8'h77, 1'b0, 1'b0, 1'b0, BC0);
            begin
                int w = 0;
                while (!rx_irq && w < 1000) begin cyc(1); w++; end
                rx_rd = 1'b0;
            end
        join
        rx_rd = 1'b0;
        cyc(2);
        chk("R12", "load beats read", rx_full, 1);
        chk("R12", "new data", rx_rdata, 8'h77);
        read_rx();
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_tx_direct();
        t_tx_nack();
        t_tx_inverse();
        t_rate();
        tx_en = 1'b0;
        t_rx_direct();
        t_rx_inverse();
        t_rx_parity();
        t_rx_frame();
        t_rx_overrun();
        t_collision();
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end
endmodule